// File: doc/BRIEF.md
# Paged Address Translator and Region Decoder

This block takes a 24-bit operand address and, in a single registered step, works out where it lives. The three low bits select a character within a word, and the 21 bits above them form the word address. The top bit of the word address splits the space into two halves. The lower half is paged main store. The upper half holds three special regions: a read-only program store, a privileged scratch store and a peripheral register store. A fourth code in the upper half is reserved.

For main-store addresses, the 11-bit page number is compared at the same moment against every page frame descriptor. There is one descriptor for each 512-word core frame, 32 frames by default. A hit returns the frame index and the in-page offset. A miss raises a page-absent trap, which the surrounding machine uses to enter its handler in the program store.

Accesses to the scratch region and to the register region are refused unless the current instruction came from the program store. The descriptors are loaded through a simple write port.

Top module: `paged_addr_xlate`

## Requirements
- R1: After a synchronous active-low reset, every response output is 0 and every frame descriptor is empty, so the first main-store lookup traps.
- R2: A lookup presented with `req_valid` at one rising edge has its result on the response outputs after that edge, with `rsp_valid` high for exactly that cycle.
- R3: Field split: `rsp_char` = addr[2:0]. For main store, `rsp_offset` = addr[11:3] and the page number is addr[22:12]. Region selection uses addr[23] and addr[22:21].
- R4: A main-store lookup whose page number equals a valid descriptor gives `rsp_hit`=1, with that descriptor's frame index in `rsp_frame` and the offset in `rsp_offset`.
- R5: A main-store lookup that matches no valid descriptor gives `rsp_trap`=1, `rsp_hit`=0 and `rsp_frame`=0.
- R6: Only descriptors whose valid bit is set can match. Writing a descriptor with `pw_valid`=0 removes it from matching.
- R7: When several valid descriptors match, the lowest frame index is returned and `rsp_multi_hit` is raised. It stays low for a single match.
- R8: Region codes on `rsp_region`: addr[23]=0 gives main (0). Otherwise addr[22:21] = 00 gives program store (1), 01 gives scratch (2), 10 gives registers (3), and 11 gives reserved (4). For special regions, `rsp_word` = addr[20:3] when access is granted, else 0.
- R9: A scratch or register access with `fetch_priv`=0 raises `rsp_fault_lock` and returns `rsp_word`=0. Program-store accesses are never locked.
- R10: A reserved-code access raises `rsp_fault_rsvd` and nothing else.
- R11: A descriptor write is seen by lookups from the next edge on. A lookup in the same cycle as the write uses the old contents.
- R12: In a cycle with no request, every response output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 24 | Operand address |
| fetch_priv | input | 1 | Current instruction came from the program store |
| pw_en | input | 1 | Descriptor write enable |
| pw_frame | input | 5 | Frame index to write |
| pw_block | input | 11 | Page number to hold |
| pw_valid | input | 1 | Valid bit to write |
| rsp_valid | output | 1 | Result present |
| rsp_region | output | 3 | Region code (R8) |
| rsp_hit | output | 1 | Main-store page found |
| rsp_frame | output | 5 | Matching frame index |
| rsp_offset | output | 9 | Word offset within page |
| rsp_char | output | 3 | Character position |
| rsp_word | output | 18 | Word index within a special region |
| rsp_trap | output | 1 | Page-absent trap |
| rsp_fault_lock | output | 1 | Privilege lock-out violation |
| rsp_fault_rsvd | output | 1 | Reserved region access |
| rsp_multi_hit | output | 1 | More than one descriptor matched |

## Verification
Duplicate page numbers are loaded into frames 3 and 7. A priority encoder that favoured the highest index, or that did not flag the duplicate, would return frame 7 or leave `rsp_multi_hit` low. Other cases:
- A descriptor is rewritten in the same cycle as a lookup of its page, and then invalidated. A design that bypassed the write, or that matched on stale valid bits, would report a hit too early, or one that should be gone.
- Lock-out is tested with and without privilege across all four upper-half codes, so a decoder that swapped codes or locked the program store would raise the wrong fault.
- Random lookups over a small page pool force frequent hits, misses and duplicates against a bench model.

// File: rtl/pax_pkg.sv
// Shared types for the paged address translator.
// Assumes region codes are consumed numerically by the trap logic downstream.
package pax_pkg;
    typedef enum logic [2:0] {
        RG_MAIN  = 3'd0,
        RG_FIXED = 3'd1,
        RG_SUBS  = 3'd2,
        RG_REGS  = 3'd3,
        RG_RSVD  = 3'd4
    } region_e;
endpackage

// File: rtl/pax_region_decode.sv
// Decodes the top bits of a word address into a store region.
// Assumes the top bit selects main store when 0 and a 2-bit code below it otherwise.
module pax_region_decode
    import pax_pkg::*;
#(
    parameter int WORD_W = 21
) (
    input  logic [WORD_W-1:0] word_addr,
    output region_e           region
);
    // Pick the region from the select bit and the code beneath it.
    always_comb begin
        if (!word_addr[WORD_W-1]) begin
            region = RG_MAIN;
        end else begin
            case (word_addr[WORD_W-2:WORD_W-3])
                2'b00:   region = RG_FIXED;
                2'b01:   region = RG_SUBS;
                2'b10:   region = RG_REGS;
                default: region = RG_RSVD;
            endcase
        end
    end
endmodule

// File: rtl/pax_page_bank.sv
// Bank of page frame descriptors with a parallel compare of every entry.
// Assumes one write per cycle; a write is visible to compares after the edge.
module pax_page_bank #(
    parameter int NFRAME = 32,
    parameter int BLK_W  = 11,
    localparam int IDX_W = $clog2(NFRAME)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BLK_W-1:0]  wr_blk,
    input  logic              wr_vld,
    input  logic [BLK_W-1:0]  look_blk,
    output logic [NFRAME-1:0] match
);
    genvar g;
    generate
        for (g = 0; g < NFRAME; g++) begin : g_frame
            logic             ent_vld;
            logic [BLK_W-1:0] ent_blk;

            // Hold one descriptor; reset empties it, a write to its index reloads it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_vld <= 1'b0;
                    ent_blk <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    ent_vld <= wr_vld;
                    ent_blk <= wr_blk;
                end
            end

            // Compare this entry's page number against the lookup.
            always_comb match[g] = ent_vld && (ent_blk == look_blk);
        end
    endgenerate
endmodule

// File: rtl/pax_first_match.sv
// Lowest-index priority encoder with a multiple-match flag.
// Assumes the index output is 0 whenever no bit is set.
module pax_first_match #(
    parameter int N = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic             multi
);
    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

    // Any bit set, and more than one bit set (clearing the lowest leaves some).
    always_comb begin
        any   = |vec;
        multi = |(vec & (vec - N'(1)));
    end
endmodule

// File: rtl/paged_addr_xlate.sv
// Paged address translator: splits an operand address, decodes its region,
// matches main-store page numbers against every frame descriptor at once,
// and registers the result with lock-out and trap flags.
// Assumes fetch_priv describes the instruction issuing the lookup.
module paged_addr_xlate
    import pax_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CHAR_W = 3,
    parameter int OFS_W  = 9,
    parameter int NFRAME = 32,
    localparam int IDX_W  = $clog2(NFRAME),
    localparam int WORD_W = ADDR_W - CHAR_W,
    localparam int BLK_W  = WORD_W - 1 - OFS_W,
    localparam int SPC_W  = WORD_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              fetch_priv,
    input  logic              pw_en,
    input  logic [IDX_W-1:0]  pw_frame,
    input  logic [BLK_W-1:0]  pw_block,
    input  logic              pw_valid,
    output logic              rsp_valid,
    output logic [2:0]        rsp_region,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_frame,
    output logic [OFS_W-1:0]  rsp_offset,
    output logic [CHAR_W-1:0] rsp_char,
    output logic [SPC_W-1:0]  rsp_word,
    output logic              rsp_trap,
    output logic              rsp_fault_lock,
    output logic              rsp_fault_rsvd,
    output logic              rsp_multi_hit
);
    logic [WORD_W-1:0] word_a;
    logic [BLK_W-1:0]  blk_a;
    region_e           region_d;
    logic [NFRAME-1:0] match_v;
    logic              any_hit;
    logic [IDX_W-1:0]  hit_idx;
    logic              multi_d;

    // Separate the word address and page number from the operand address.
    always_comb begin
        word_a = req_addr[ADDR_W-1:CHAR_W];
        blk_a  = word_a[WORD_W-2:OFS_W];
    end

    pax_region_decode #(.WORD_W(WORD_W)) dec_i (
        .word_addr (word_a),
        .region    (region_d)
    );

    pax_page_bank #(.NFRAME(NFRAME), .BLK_W(BLK_W)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (pw_en),
        .wr_idx   (pw_frame),
        .wr_blk   (pw_block),
        .wr_vld   (pw_valid),
        .look_blk (blk_a),
        .match    (match_v)
    );

    pax_first_match #(.N(NFRAME)) pick_i (
        .vec   (match_v),
        .any   (any_hit),
        .idx   (hit_idx),
        .multi (multi_d)
    );

    logic              is_main, is_lockable, granted_spc;
    logic              n_hit, n_trap, n_lock, n_rsvd, n_multi;
    logic [2:0]        n_region;
    logic [IDX_W-1:0]  n_frame;
    logic [OFS_W-1:0]  n_offset;
    logic [CHAR_W-1:0] n_char;
    logic [SPC_W-1:0]  n_word;

    // Form the next response; everything is zero when no request is present.
    always_comb begin
        is_main     = req_valid && (region_d == RG_MAIN);
        is_lockable = req_valid && ((region_d == RG_SUBS) || (region_d == RG_REGS));
        granted_spc = req_valid && ((region_d == RG_FIXED) || (is_lockable && fetch_priv));
        n_region    = req_valid ? region_d : 3'd0;
        n_hit       = is_main && any_hit;
        n_trap      = is_main && !any_hit;
        n_multi     = n_hit && multi_d;
        n_frame     = n_hit ? hit_idx : '0;
        n_offset    = is_main ? word_a[OFS_W-1:0] : '0;
        n_char      = req_valid ? req_addr[CHAR_W-1:0] : '0;
        n_word      = granted_spc ? word_a[SPC_W-1:0] : '0;
        n_lock      = is_lockable && !fetch_priv;
        n_rsvd      = req_valid && (region_d == RG_RSVD);
    end

    // Register the response one edge after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_region     <= 3'd0;
            rsp_hit        <= 1'b0;
            rsp_frame      <= '0;
            rsp_offset     <= '0;
            rsp_char       <= '0;
            rsp_word       <= '0;
            rsp_trap       <= 1'b0;
            rsp_fault_lock <= 1'b0;
            rsp_fault_rsvd <= 1'b0;
            rsp_multi_hit  <= 1'b0;
        end else begin
            rsp_valid      <= req_valid;
            rsp_region     <= n_region;
            rsp_hit        <= n_hit;
            rsp_frame      <= n_frame;
            rsp_offset     <= n_offset;
            rsp_char       <= n_char;
            rsp_word       <= n_word;
            rsp_trap       <= n_trap;
            rsp_fault_lock <= n_lock;
            rsp_fault_rsvd <= n_rsvd;
            rsp_multi_hit  <= n_multi;
        end
    end
endmodule

// File: rtl/pax_checker.sv
// Property checker for the paged address translator, bound to its top.
// Assumes the default field layout of the top module's parameters.
module pax_checker #(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              fetch_priv,
    input logic              rsp_valid,
    input logic [2:0]        rsp_region,
    input logic              rsp_hit,
    input logic [IDX_W-1:0]  rsp_frame,
    input logic              rsp_trap,
    input logic              rsp_fault_lock,
    input logic              rsp_fault_rsvd,
    input logic              rsp_multi_hit
);
    p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_hit && !rsp_trap && !rsp_fault_lock && !rsp_fault_rsvd);

    p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_trap, rsp_fault_lock, rsp_fault_rsvd}));

    p_trap_main_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (rsp_region == 3'd0) && rsp_valid);

    p_hit_main_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_region == 3'd0) && rsp_valid);

    p_multi_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi_hit |-> rsp_hit);

    p_frame_zero_on_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_frame == '0));

    p_lock_raised_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !fetch_priv && req_addr[ADDR_W-1] &&
         (req_addr[ADDR_W-2:ADDR_W-3] inside {2'b01, 2'b10})) |=> rsp_fault_lock);

    p_fixed_never_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[ADDR_W-1:ADDR_W-3] == 3'b100) |=> !rsp_fault_lock && (rsp_region == 3'd1));

    p_rsvd_region_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault_rsvd |-> (rsp_region == 3'd4));
endmodule

bind paged_addr_xlate pax_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .fetch_priv     (fetch_priv),
    .rsp_valid      (rsp_valid),
    .rsp_region     (rsp_region),
    .rsp_hit        (rsp_hit),
    .rsp_frame      (rsp_frame),
    .rsp_trap       (rsp_trap),
    .rsp_fault_lock (rsp_fault_lock),
    .rsp_fault_rsvd (rsp_fault_rsvd),
    .rsp_multi_hit  (rsp_multi_hit)
);

// File: tb/paged_addr_xlate_tb.sv
// Self-checking bench: directed corners plus seeded random lookups and writes,
// compared against a descriptor model kept in the bench.
module paged_addr_xlate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        fetch_priv = 1'b0;
    logic        pw_en = 1'b0;
    logic [4:0]  pw_frame = '0;
    logic [10:0] pw_block = '0;
    logic        pw_valid = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_trap, rsp_fault_lock, rsp_fault_rsvd, rsp_multi_hit;
    logic [2:0]  rsp_region;
    logic [4:0]  rsp_frame;
    logic [8:0]  rsp_offset;
    logic [2:0]  rsp_char;
    logic [17:0] rsp_word;

    int n_checks = 0;
    int n_fail = 0;
    logic        m_vld [NF];
    logic [10:0] m_blk [NF];

    always #(CLK_PERIOD/2) clk = ~clk;

    paged_addr_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .fetch_priv(fetch_priv), .pw_en(pw_en), .pw_frame(pw_frame),
        .pw_block(pw_block), .pw_valid(pw_valid), .rsp_valid(rsp_valid),
        .rsp_region(rsp_region), .rsp_hit(rsp_hit), .rsp_frame(rsp_frame),
        .rsp_offset(rsp_offset), .rsp_char(rsp_char), .rsp_word(rsp_word),
        .rsp_trap(rsp_trap), .rsp_fault_lock(rsp_fault_lock),
        .rsp_fault_rsvd(rsp_fault_rsvd), .rsp_multi_hit(rsp_multi_hit)
    );

    // Expected response vector from the requirements and the model state.
    function automatic logic [43:0] expect_rsp(input logic v, input logic [23:0] a, input logic pr);
        logic [2:0] rg; logic hit, trap, lock, rsvd, multi; logic [4:0] fr;
        logic [8:0] ofs; logic [17:0] wd; int cnt;
        if (!v) return '0;
        rg = !a[23] ? 3'd0 : (a[22:21] == 2'b00 ? 3'd1 : a[22:21] == 2'b01 ? 3'd2 :
                              a[22:21] == 2'b10 ? 3'd3 : 3'd4);
        hit = 0; fr = 0; cnt = 0; ofs = 0; wd = 0;
        if (rg == 3'd0) begin
            ofs = a[11:3];
            for (int i = NF - 1; i >= 0; i--)
                if (m_vld[i] && m_blk[i] == a[22:12]) begin fr = 5'(i); cnt++; end
            hit = (cnt > 0);
        end
        trap = (rg == 3'd0) && !hit;
        multi = (cnt > 1);
        lock = (rg == 3'd2 || rg == 3'd3) && !pr;
        rsvd = (rg == 3'd4);
        if (rg == 3'd1 || ((rg == 3'd2 || rg == 3'd3) && pr)) wd = a[20:3];
        return {1'b1, rg, hit, fr, ofs, a[2:0], wd, trap, lock, rsvd, multi};
    endfunction

    function automatic logic [43:0] actual_rsp();
        return {rsp_valid, rsp_region, rsp_hit, rsp_frame, rsp_offset, rsp_char,
                rsp_word, rsp_trap, rsp_fault_lock, rsp_fault_rsvd, rsp_multi_hit};
    endfunction

    task automatic check(input string tag, input logic [43:0] act, input logic [43:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive, let the edge capture, update model, sample mid-cycle.
    task automatic step(input string tag, input logic v, input logic [23:0] a, input logic pr,
                        input logic we, input logic [4:0] wf, input logic [10:0] wb, input logic wv);
        logic [43:0] exp;
        req_valid = v; req_addr = a; fetch_priv = pr;
        pw_en = we; pw_frame = wf; pw_block = wb; pw_valid = wv;
        exp = expect_rsp(v, a, pr);  // R11: lookup sees contents before the write
        @(posedge clk);
        if (we) begin m_vld[wf] = wv; m_blk[wf] = wb; end
        @(negedge clk);
        check(tag, actual_rsp(), exp);
        req_valid = 0; pw_en = 0;
    endtask

    function automatic logic [23:0] main_a(input logic [10:0] b, input logic [8:0] o, input logic [2:0] c);
        return {1'b0, b, o, c};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
        $finish;
    end

    initial begin : main_flow
        void'($urandom(32'd2024));
        for (int i = 0; i < NF; i++) begin m_vld[i] = 0; m_blk[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset outputs", actual_rsp(), '0);
        rst_n = 1;
        step("R1 empty bank traps", 1, main_a(11'd0, 9'd5, 3'd1), 1, 0, 0, 0, 0);
        step("R12 idle", 0, 24'hFFFFFF, 0, 0, 0, 0, 0);
        // R11: write frame 3 and look up same page in the same cycle -> old (miss)
        step("R11 same-cycle miss", 1, main_a(11'd100, 9'd7, 3'd2), 1, 1, 5'd3, 11'd100, 1);
        step("R4 hit frame 3", 1, main_a(11'd100, 9'd511, 3'd7), 0, 0, 0, 0, 0);
        step("R7 load dup frame 7", 0, 0, 0, 1, 5'd7, 11'd100, 1);
        step("R7 dup lowest frame", 1, main_a(11'd100, 9'd0, 3'd0), 0, 0, 0, 0, 0);
        step("R6 invalidate 3", 0, 0, 0, 1, 5'd3, 11'd100, 0);
        step("R6 frame 7 single", 1, main_a(11'd100, 9'd33, 3'd4), 0, 0, 0, 0, 0);
        step("R6 invalidate 7", 0, 0, 0, 1, 5'd7, 11'd100, 0);
        step("R5 invalid no hit", 1, main_a(11'd100, 9'd33, 3'd4), 0, 0, 0, 0, 0);
        step("R3 top frame", 0, 0, 0, 1, 5'd31, 11'h7FF, 1);
        step("R3 top page hit", 1, main_a(11'h7FF, 9'h155, 3'd5), 0, 0, 0, 0, 0);
        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < 2; p++) begin
                step(c == 3 ? "R10 reserved" : (c == 0 ? "R8 fixed region" : "R9 lockout"),
                     1, {1'b1, 2'(c), 18'h2A5C3, 3'd6}, 1'(p), 0, 0, 0, 0);
            end
        end
        step("R12 idle after faults", 0, 0, 1, 0, 0, 0, 0);
        for (int n = 0; n < 3000; n++) begin
            logic [23:0] a; logic [2:0] kind;
            kind = 3'($urandom % 8);
            a = 24'($urandom);
            if (kind < 5) a = main_a(11'($urandom % 24), a[11:3], a[2:0]);
            step(a[23] ? "R8 random special" : "R4 random main",
                 1'($urandom % 8 != 0), a, 1'($urandom % 2),
                 1'($urandom % 3 == 0), 5'($urandom), 11'($urandom % 24),
                 1'($urandom % 4 != 0));
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule